// File: doc/BRIEF.md
# Quadrature Encoder Position Counter

The block turns the two phase signals and the index pulse of an incremental rotary or linear encoder into a signed-direction position count. It counts on every edge of both phases, so one full encoder cycle gives four counts. Its inputs must already be synchronised to the clock and cleaned of spikes. Software-facing control arrives as plain configuration inputs. Events come out as sticky status bits with per-bit masking and a single interrupt line. A phase swap input reverses the sense of rotation without rewiring.

The position is bounded by a programmable ceiling. One of two reset behaviours is selected. In wrap mode the count rolls over at the ceiling and at zero, and each roll-over is reported as a reset event. In preset mode the count is cleared by an index pulse, but only when the phases sit at a chosen pair of levels. The ceiling and the reset mode are captured only while counting is stopped. A watchdog reports a stalled encoder.

Top module: `qenc_counter_core`

## Requirements
- R1: While enabled, every change of exactly one logical phase moves the count by one. A edge with A!=B after the change, or B edge with A==B after the change, counts up (logical A leading B: AB 00,10,11,01 counts up); dir_up shows the direction of the last valid step.
- R2: While enable is 0 the count does not change and no event bit is set by phase or index activity.
- R3: The ceiling and wrap_mode inputs are taken only on clock edges where enable is 0; changing them while enabled has no effect until the block is stopped again.
- R4: Counting up from a count equal to or above the ceiling gives 0; counting down from 0 gives the ceiling. This holds in both reset modes.
- R5: With swap_ab = 1 the physical phases exchange roles, so a sequence that counts up without swap counts down.
- R6: In preset mode (wrap_mode = 0), a rising edge of idx while enabled clears the count when the logical levels {A,B} equal idx_gate (0: A low B low, 1: A low B high, 2: A high B low, 3: A high B high); otherwise the pulse is ignored. The index clear wins over a same-cycle step.
- R7: Status bit 2 flags a reset while counting up and bit 1 a reset while counting down. In wrap mode (wrap_mode = 1) the up roll-over sets bit 2 and the down roll-over sets bit 1, and idx has no effect. In preset mode an index clear sets bit 2 if dir_up is 1, else bit 1.
- R8: Status bit 3 is set when a valid step goes in the opposite direction to dir_up; after reset dir_up is 1.
- R9: When both phases change in the same cycle, the count and dir_up are left unchanged and phase_err is set and stays set until reset.
- R10: With wdog_limit nonzero, status bit 0 is set after wdog_limit consecutive enabled clock cycles without a valid step, and the idle count then restarts; wdog_limit = 0 turns the watchdog off.
- R11: Status bits are sticky and are cleared by a one in the matching bit of clr_status; an event in the same cycle as its clear leaves the bit set.
- R12: irq is high when any status bit is set whose irq_mask bit is 0; a mask bit of 1 blocks its status bit.
- R13: After reset the count is 0, dir_up is 1, status is 0, irq is 0 and phase_err is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| enable | input | 1 | Counting enable |
| swap_ab | input | 1 | Exchange phase A and phase B |
| wrap_mode | input | 1 | 1: roll over at ceiling, 0: preset by gated index |
| idx_gate | input | 2 | Phase levels {A,B} required for an index clear |
| ceiling | input | CNT_W | Upper bound of the count |
| wdog_limit | input | WDT_W | Idle cycles before a watchdog event, 0 = off |
| pha | input | 1 | Phase A level |
| phb | input | 1 | Phase B level |
| idx | input | 1 | Index pulse level |
| clr_status | input | 4 | Write-one-to-clear pulses for the status bits |
| irq_mask | input | 4 | One bit per status bit, 1 blocks it from irq |
| count | output | CNT_W | Position count |
| dir_up | output | 1 | Direction of the last valid step, 1 = up |
| status | output | 4 | Sticky events: 0 watchdog, 1 reset down, 2 reset up, 3 direction change |
| irq | output | 1 | Unmasked event pending |
| phase_err | output | 1 | Sticky two-phase-change error |

## Verification
The hardest situations to reach are the coincidences: a clear pulse landing in the very cycle that a direction-reversing edge sets the same status bit, and an index pulse arriving while the phases sit at exactly the gated level pair. The stimulus walks the phases to a known level pair before raising the index. It drives the clear pulse together with the reversing edge at the same falling clock edge. The watchdog is armed from a known idle point so the status bit can be sampled one cycle before and exactly at the programmed limit.

// File: rtl/qenc_pkg.sv
`timescale 1ns/1ps
package qenc_pkg;
    localparam int NUM_EV    = 4;
    localparam int EV_WDOG   = 0;
    localparam int EV_RST_DN = 1;
    localparam int EV_RST_UP = 2;
    localparam int EV_DIR    = 3;

    typedef enum logic {
        MODE_PRESET = 1'b0,
        MODE_WRAP   = 1'b1
    } rst_mode_e;

    typedef struct packed {
        logic a;
        logic b;
    } qphase_t;

    typedef struct packed {
        logic step;
        logic up;
        logic err;
    } qstep_t;

    function automatic qphase_t apply_swap(qphase_t p, logic swap);
        qphase_t r;
        r.a = swap ? p.b : p.a;
        r.b = swap ? p.a : p.b;
        return r;
    endfunction

    // Compare two successive logical level pairs and classify the move.
    function automatic qstep_t decode_step(qphase_t prev, qphase_t cur, logic en);
        qstep_t r;
        logic da;
        logic db;
        da     = cur.a ^ prev.a;
        db     = cur.b ^ prev.b;
        r.err  = en & da & db;
        r.step = en & (da ^ db);
        r.up   = da ? (cur.a ^ cur.b) : ~(cur.a ^ cur.b);
        return r;
    endfunction

    function automatic logic gate_hit(logic [1:0] sel, qphase_t p);
        return sel == {p.a, p.b};
    endfunction
endpackage

// File: rtl/qenc_edge_decode.sv
`timescale 1ns/1ps
module qenc_edge_decode
    import qenc_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       enable,
    input  logic       swap_ab,
    input  logic [1:0] idx_gate,
    input  logic       pha,
    input  logic       phb,
    input  logic       idx,
    output qstep_t     st,
    output logic       idx_hit
);
    qphase_t raw_cur;
    qphase_t raw_prev;
    qphase_t cur;
    qphase_t prev;
    logic    idx_q;

    // Previous levels track the pins in every cycle, so stopping or
    // resetting never leaves a stale level that would fake an edge.
    always_ff @(posedge clk) begin
        if (rst) begin
            raw_prev.a <= pha;
            raw_prev.b <= phb;
            idx_q      <= idx;
        end else begin
            raw_prev.a <= pha;
            raw_prev.b <= phb;
            idx_q      <= idx;
        end
    end

    always_comb begin
        raw_cur.a = pha;
        raw_cur.b = phb;
        cur       = apply_swap(raw_cur, swap_ab);
        prev      = apply_swap(raw_prev, swap_ab);
        st        = decode_step(prev, cur, enable);
        idx_hit   = enable & idx & ~idx_q & gate_hit(idx_gate, cur);
    end
endmodule

// File: rtl/qenc_position.sv
`timescale 1ns/1ps
module qenc_position
    import qenc_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             enable,
    input  qstep_t           st,
    input  logic             idx_hit,
    input  logic [CNT_W-1:0] ceiling,
    input  logic             wrap_mode,
    output logic [CNT_W-1:0] count,
    output logic             dir_up,
    output logic             phase_err,
    output logic             ev_rst_up,
    output logic             ev_rst_dn,
    output logic             ev_dir
);
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] ceil_q;
    rst_mode_e        mode_q;
    logic             dir_q;
    logic             perr_q;
    logic             idx_act;
    logic             at_top;
    logic             at_zero;
    logic [CNT_W-1:0] cnt_nxt;

    always_comb begin
        idx_act   = idx_hit && (mode_q == MODE_PRESET);
        at_top    = cnt_q >= ceil_q;
        at_zero   = cnt_q == '0;
        if (st.up) cnt_nxt = at_top ? '0 : cnt_q + 1'b1;
        else       cnt_nxt = at_zero ? ceil_q : cnt_q - 1'b1;
        ev_rst_up = (idx_act && dir_q) ||
                    (!idx_act && mode_q == MODE_WRAP && st.step && st.up && at_top);
        ev_rst_dn = (idx_act && !dir_q) ||
                    (!idx_act && mode_q == MODE_WRAP && st.step && !st.up && at_zero);
        ev_dir    = st.step && (st.up != dir_q);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q  <= '0;
            ceil_q <= '0;
            mode_q <= MODE_WRAP;
            dir_q  <= 1'b1;
            perr_q <= 1'b0;
        end else begin
            if (!enable) begin
                ceil_q <= ceiling;
                mode_q <= rst_mode_e'(wrap_mode);
            end
            if (st.err) perr_q <= 1'b1;
            if (st.step) dir_q <= st.up;
            if (idx_act) cnt_q <= '0;
            else if (st.step) cnt_q <= cnt_nxt;
        end
    end

    assign count     = cnt_q;
    assign dir_up    = dir_q;
    assign phase_err = perr_q;

    AST_HOLD_WHEN_OFF: assert property (@(posedge clk) disable iff (rst)
        !enable |=> cnt_q == $past(cnt_q)); // R2
    AST_CFG_LOCKED: assert property (@(posedge clk) disable iff (rst)
        enable |=> $stable(ceil_q) && $stable(mode_q)); // R3
    AST_WRAP_UP: assert property (@(posedge clk) disable iff (rst)
        st.step && st.up && at_top && !idx_act |=> cnt_q == '0); // R4
    AST_WRAP_DOWN: assert property (@(posedge clk) disable iff (rst)
        st.step && !st.up && at_zero && !idx_act |=> cnt_q == $past(ceil_q)); // R4
    AST_INDEX_CLEARS: assert property (@(posedge clk) disable iff (rst)
        idx_act |=> cnt_q == '0); // R6
    AST_PHASE_ERR_HOLD: assert property (@(posedge clk) disable iff (rst)
        st.err && !idx_act |=> cnt_q == $past(cnt_q) && perr_q); // R9
endmodule

// File: rtl/qenc_watchdog.sv
`timescale 1ns/1ps
module qenc_watchdog #(
    parameter int WDT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             enable,
    input  logic             step,
    input  logic [WDT_W-1:0] limit,
    output logic             fire
);
    logic [WDT_W-1:0] idle_q;
    logic             armed;

    always_comb begin
        armed = enable && !step && (limit != '0);
        fire  = armed && (idle_q == limit - 1'b1);
    end

    always_ff @(posedge clk) begin
        if (rst || !armed || fire) idle_q <= '0;
        else                       idle_q <= idle_q + 1'b1;
    end

    AST_WDOG_QUIET_ON_STEP: assert property (@(posedge clk) disable iff (rst)
        step |=> idle_q == '0); // R10
endmodule

// File: rtl/qenc_event_regs.sv
`timescale 1ns/1ps
module qenc_event_regs #(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] ev,
    input  logic [N-1:0] clr,
    input  logic [N-1:0] mask,
    output logic [N-1:0] status,
    output logic         irq
);
    for (genvar i = 0; i < N; i++) begin : g_bit
        logic bit_q;
        always_ff @(posedge clk) begin
            if (rst) bit_q <= 1'b0;
            else     bit_q <= ev[i] | (bit_q & ~clr[i]);
        end
        assign status[i] = bit_q;

        AST_STICKY_BIT: assert property (@(posedge clk) disable iff (rst)
            bit_q && !clr[i] |=> bit_q); // R11
        AST_EVENT_BEATS_CLEAR: assert property (@(posedge clk) disable iff (rst)
            ev[i] |=> bit_q); // R11
    end

    assign irq = |(status & ~mask);
endmodule

// File: rtl/qenc_counter_core.sv
`timescale 1ns/1ps
module qenc_counter_core
    import qenc_pkg::*;
#(
    parameter int CNT_W = 32,
    parameter int WDT_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              enable,
    input  logic              swap_ab,
    input  logic              wrap_mode,
    input  logic [1:0]        idx_gate,
    input  logic [CNT_W-1:0]  ceiling,
    input  logic [WDT_W-1:0]  wdog_limit,
    input  logic              pha,
    input  logic              phb,
    input  logic              idx,
    input  logic [NUM_EV-1:0] clr_status,
    input  logic [NUM_EV-1:0] irq_mask,
    output logic [CNT_W-1:0]  count,
    output logic              dir_up,
    output logic [NUM_EV-1:0] status,
    output logic              irq,
    output logic              phase_err
);
    qstep_t            st;
    logic              idx_hit;
    logic              ev_rst_up;
    logic              ev_rst_dn;
    logic              ev_dir;
    logic              ev_wdog;
    logic [NUM_EV-1:0] ev;

    qenc_edge_decode u_dec (
        .clk      (clk),
        .rst      (rst),
        .enable   (enable),
        .swap_ab  (swap_ab),
        .idx_gate (idx_gate),
        .pha      (pha),
        .phb      (phb),
        .idx      (idx),
        .st       (st),
        .idx_hit  (idx_hit)
    );

    qenc_position #(.CNT_W(CNT_W)) u_pos (
        .clk       (clk),
        .rst       (rst),
        .enable    (enable),
        .st        (st),
        .idx_hit   (idx_hit),
        .ceiling   (ceiling),
        .wrap_mode (wrap_mode),
        .count     (count),
        .dir_up    (dir_up),
        .phase_err (phase_err),
        .ev_rst_up (ev_rst_up),
        .ev_rst_dn (ev_rst_dn),
        .ev_dir    (ev_dir)
    );

    qenc_watchdog #(.WDT_W(WDT_W)) u_wdog (
        .clk    (clk),
        .rst    (rst),
        .enable (enable),
        .step   (st.step),
        .limit  (wdog_limit),
        .fire   (ev_wdog)
    );

    always_comb begin
        ev            = '0;
        ev[EV_WDOG]   = ev_wdog;
        ev[EV_RST_DN] = ev_rst_dn;
        ev[EV_RST_UP] = ev_rst_up;
        ev[EV_DIR]    = ev_dir;
    end

    qenc_event_regs #(.N(NUM_EV)) u_evt (
        .clk    (clk),
        .rst    (rst),
        .ev     (ev),
        .clr    (clr_status),
        .mask   (irq_mask),
        .status (status),
        .irq    (irq)
    );

    AST_NO_EVENT_WHEN_OFF: assert property (@(posedge clk) disable iff (rst)
        !enable |=> (status & ~$past(status)) == '0); // R2
endmodule

// File: tb/sim_qenc_counter_core.sv
`timescale 1ns/1ps
module sim_qenc_counter_core;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        enable = 1'b0;
    logic        swap_ab = 1'b0;
    logic        wrap_mode = 1'b1;
    logic [1:0]  idx_gate = 2'd0;
    logic [31:0] ceiling = 32'd5;
    logic [15:0] wdog_limit = 16'd0;
    logic        pha = 1'b0;
    logic        phb = 1'b0;
    logic        idx = 1'b0;
    logic [3:0]  clr_status = 4'd0;
    logic [3:0]  irq_mask = 4'd0;
    logic [31:0] count;
    logic        dir_up;
    logic [3:0]  status;
    logic        irq;
    logic        phase_err;

    int total = 0;
    int fails = 0;
    bit done = 1'b0;

    qenc_counter_core u0 (
        .clk(clk), .rst(rst), .enable(enable), .swap_ab(swap_ab),
        .wrap_mode(wrap_mode), .idx_gate(idx_gate), .ceiling(ceiling),
        .wdog_limit(wdog_limit), .pha(pha), .phb(phb), .idx(idx),
        .clr_status(clr_status), .irq_mask(irq_mask), .count(count),
        .dir_up(dir_up), .status(status), .irq(irq), .phase_err(phase_err)
    );

    always #2 clk = ~clk;

    // {A, B, expected count} with ceiling 5 in roll-over mode, from AB=00, count 0
    localparam logic [9:0] VEC [0:13] = '{
        {1'b1, 1'b0, 8'd1}, {1'b1, 1'b1, 8'd2}, {1'b0, 1'b1, 8'd3},
        {1'b0, 1'b0, 8'd4}, {1'b1, 1'b0, 8'd5}, {1'b1, 1'b1, 8'd0},
        {1'b1, 1'b0, 8'd5}, {1'b0, 1'b0, 8'd4}, {1'b0, 1'b1, 8'd3},
        {1'b1, 1'b1, 8'd2}, {1'b1, 1'b0, 8'd1}, {1'b0, 1'b0, 8'd0},
        {1'b0, 1'b1, 8'd5}, {1'b0, 1'b0, 8'd0}
    };

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic step(input logic a, input logic b);
        pha = a;
        phb = b;
        tick();
    endtask

    task automatic clear_all();
        clr_status = 4'hF;
        tick();
        clr_status = 4'h0;
    endtask

    task automatic pulse_idx();
        idx = 1'b1;
        tick();
    endtask

    task automatic drop_idx();
        idx = 1'b0;
        tick();
    endtask

    initial begin
        repeat (3) tick();
        rst = 1'b0;
        tick();
        // R13: reset state
        chk("R13", count, 0);
        chk("R13", {31'd0, dir_up}, 1);
        chk("R13", {28'd0, status}, 0);
        chk("R13", {31'd0, irq}, 0);
        chk("R13", {31'd0, phase_err}, 0);
        tick();
        enable = 1'b1;
        tick();

        // R1 / R4: table of x4 steps in both directions with roll-over
        for (int i = 0; i < 14; i++) begin
            step(VEC[i][9], VEC[i][8]);
            chk("R1", count, {24'd0, VEC[i][7:0]});
        end
        chk("R1", {31'd0, dir_up}, 1);
        // R7: roll-over up, roll-over down and reversals seen in the table
        chk("R7", {28'd0, status}, 4'b1110);

        // R2: stopped block ignores phase moves
        enable = 1'b0;
        tick();
        step(1'b1, 1'b0);
        chk("R2", count, 0);
        step(1'b0, 1'b0);
        chk("R2", {28'd0, status}, 4'b1110);

        // R3: ceiling change while running has no effect
        enable = 1'b1;
        tick();
        ceiling = 32'd2;
        step(1'b1, 1'b0);
        step(1'b1, 1'b1);
        step(1'b0, 1'b1);
        chk("R3", count, 3);
        step(1'b0, 1'b0);
        step(1'b1, 1'b0);
        step(1'b1, 1'b1);
        chk("R3", count, 0);

        // new configuration while stopped: ceiling 100, preset mode
        enable = 1'b0;
        ceiling = 32'd100;
        wrap_mode = 1'b0;
        step(1'b0, 1'b0);
        tick();
        enable = 1'b1;
        swap_ab = 1'b1;
        tick();

        // R5: swapped phases reverse the direction
        step(1'b1, 1'b0);
        chk("R5", count, 100);
        chk("R5", {31'd0, dir_up}, 0);
        step(1'b0, 1'b0);
        chk("R4", count, 0);
        swap_ab = 1'b0;
        tick();

        // R11 / R8: clear, then a reversal sets bit 3
        clear_all();
        chk("R11", {28'd0, status}, 0);
        step(1'b1, 1'b0);
        step(1'b0, 1'b0);
        chk("R8", {28'd0, status}, 4'b1000);
        chk("R8", {31'd0, dir_up}, 0);
        // R11: event in the same cycle as its clear wins
        clr_status = 4'b1000;
        step(1'b1, 1'b0);
        clr_status = 4'b0000;
        chk("R11", {28'd0, status}, 4'b1000);
        clr_status = 4'b1000;
        tick();
        clr_status = 4'b0000;
        chk("R11", {28'd0, status}, 0);

        // R12: masking of the interrupt
        step(1'b0, 1'b0);
        irq_mask = 4'b1000;
        tick();
        chk("R12", {31'd0, irq}, 0);
        irq_mask = 4'b0000;
        tick();
        chk("R12", {31'd0, irq}, 1);

        // R9: both phases in one cycle
        step(1'b1, 1'b1);
        chk("R9", count, 0);
        chk("R9", {31'd0, phase_err}, 1);
        chk("R9", {31'd0, dir_up}, 0);

        // R6 / R7: gated index in preset mode
        idx_gate = 2'd3;
        step(1'b0, 1'b1);
        step(1'b0, 1'b0);
        step(1'b1, 1'b0);
        step(1'b1, 1'b1);
        chk("R1", count, 4);
        clear_all();
        pulse_idx();
        chk("R6", count, 0);
        chk("R7", {28'd0, status}, 4'b0100);
        drop_idx();
        step(1'b0, 1'b1);
        idx_gate = 2'd0;
        pulse_idx();
        chk("R6", count, 1);
        drop_idx();
        idx_gate = 2'd1;
        clear_all();
        pulse_idx();
        chk("R6", count, 0);
        chk("R7", {28'd0, status}, 4'b0100);
        drop_idx();
        step(1'b1, 1'b1);
        chk("R4", count, 100);
        clear_all();
        idx_gate = 2'd3;
        pulse_idx();
        chk("R6", count, 0);
        chk("R7", {28'd0, status}, 4'b0010);
        drop_idx();

        // R10: watchdog at exactly the programmed idle length
        clear_all();
        wdog_limit = 16'd10;
        repeat (9) tick();
        chk("R10", {31'd0, status[0]}, 0);
        tick();
        chk("R10", {31'd0, status[0]}, 1);
        wdog_limit = 16'd0;
        tick();

        // R7: index has no effect in roll-over mode
        enable = 1'b0;
        wrap_mode = 1'b1;
        tick();
        enable = 1'b1;
        tick();
        step(1'b0, 1'b1);
        clear_all();
        idx_gate = 2'd1;
        pulse_idx();
        chk("R7", count, 1);
        chk("R7", {28'd0, status}, 0);
        drop_idx();

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", total, fails);
        $finish;
    end

    initial begin
        #(4 * 200000);
        if (!done) begin
            total++;
            fails++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", total, fails);
            $finish;
        end
    end
endmodule